// File: doc/BRIEF.md
# Register-Mapped Vectored Interrupt Controller

This block gathers a set of interrupt request lines and drives one interrupt output towards a processor. Each line passes through a synchroniser and latches into a per-line status bit. Whether a line reacts to a rising edge or to its level is fixed per line at build time. A status bit counts as pending when the enable bit of the same line is also set. The output is raised when at least one line is pending and both master-enable bits are set.

Software works the block through a small 32-bit register bus with a word index, a write strobe, write data and combinational read data. Enables can be written whole, or changed bit by bit through write-one-to-set and write-one-to-clear aliases. Status bits are cleared by writing ones to an acknowledge alias. A vector register reports the lowest-numbered pending line. Bit n of every register belongs to line n.

Top module: `intc_top`

## Requirements
- R1: After a synchronous reset, status, enable and master enable read as zero, `irq_out` is low and the vector (word index 6) reads 0xFFFFFFFF.
- R2: Every input passes through two register stages. A status bit can first read as set after the third rising clock edge following the input's change.
- R3: An edge-sense line (a zero bit in `LEVEL_MASK`) sets its status bit (word index 0) on a synchronised rising edge. The bit stays set after the input falls, until it is acknowledged.
- R4: A level-sense line (a one bit in `LEVEL_MASK`) sets its status bit whenever its synchronised input is high. If it is acknowledged while the input is still high, the bit still reads as set in the following cycle.
- R5: Writing a mask to the acknowledge alias (word index 3) clears the status bits where the mask is one and leaves the other bits alone. An all-ones mask clears every latched edge line.
- R6: Writing a mask to the set-enable alias (word index 4) sets the enable bits where the mask is one and leaves the other enable bits unchanged.
- R7: Writing a mask to the clear-enable alias (word index 5) clears the enable bits where the mask is one and leaves the other enable bits unchanged.
- R8: The enable register (word index 2) can be written directly and reads back what was written. The acknowledge, set-enable and clear-enable aliases read as zero.
- R9: The pending register (word index 1) reads as status AND enable.
- R10: The master-enable register (word index 7) holds two bits. Bit 0 follows each write. Bit 1 stays set once written as one, until reset. `irq_out` is high exactly when both bits are one and at least one line is pending.
- R11: The vector register returns the number of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R12: Writes to the status, pending and vector indices change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt request lines |
| bus_idx | input | 3 | Register word index (byte offset divided by four) |
| bus_wr | input | 1 | Write strobe for the indexed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the indexed register |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `irq_in` may change at any time and that at most one register write arrives per cycle. They also assume that `rst` is held for at least as many cycles as the synchroniser is deep, so the edge detector starts from a low history. The bench changes inputs only on falling edges and holds reset for three cycles. It keeps every write aligned to a single cycle. Interrupt inputs are raised and lowered both while their lines are enabled and while they are not, so that the sticky, re-asserting and masked cases all occur.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int DATA_W  = 32;
    localparam int MAX_LINES = 32;
    localparam int IDX_W   = 3;

    typedef enum logic [IDX_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_MASTER = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    function automatic bus_op_t make_op(input logic wr, input logic [IDX_W-1:0] idx,
                                        input logic [DATA_W-1:0] data);
        bus_op_t op;
        op.wr   = wr;
        op.sel  = reg_sel_e'(idx);
        op.data = data;
        return op;
    endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/intc_status.sv
module intc_status #(
    parameter int           N          = 32,
    parameter logic [31:0]  LEVEL_MASK = 32'h0000_00FF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] ack_mask,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic hit;
        if (LEVEL_MASK[i]) begin : g_level
            assign hit = sync_in[i];
            // R4: a high level input leaves the bit set, acknowledge or not
            assert_level_reassert_R4: assert property (@(posedge clk) disable iff (rst)
                sync_in[i] |=> status[i]);
        end else begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= sync_in[i];
            end
            assign hit = sync_in[i] & ~prev_q;
            // R3: an edge line's bit is held until acknowledged
            assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (rst)
                (status[i] && !ack_mask[i]) |=> status[i]);
        end

        always_ff @(posedge clk) begin
            if (rst) status[i] <= 1'b0;
            else     status[i] <= hit | (status[i] & ~ack_mask[i]);
        end

        // R5: acknowledge without a new request clears the bit
        assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
            (ack_mask[i] && !hit) |=> !status[i]);
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_op_t              op,
    output logic [N-1:0]         enable,
    output logic [1:0]           master,
    output logic [N-1:0]         ack_mask
);
    logic [N-1:0] mask;
    assign mask     = op.data[N-1:0];
    assign ack_mask = (op.wr && op.sel == SEL_ACK) ? mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            master <= 2'b00;
        end else if (op.wr) begin
            case (op.sel)
                SEL_ENABLE: enable <= mask;
                SEL_SETEN:  enable <= enable | mask;
                SEL_CLREN:  enable <= enable & ~mask;
                SEL_MASTER: master <= {master[1] | op.data[1], op.data[0]};
                default: ;
            endcase
        end
    end

    assert_seten_R6: assert property (@(posedge clk) disable iff (rst)
        (op.wr && op.sel == SEL_SETEN) |=>
            ((enable & $past(mask)) == $past(mask)) &&
            ((enable & ~$past(mask)) == ($past(enable) & ~$past(mask))));

    assert_clren_R7: assert property (@(posedge clk) disable iff (rst)
        (op.wr && op.sel == SEL_CLREN) |=>
            ((enable & $past(mask)) == '0) &&
            ((enable & ~$past(mask)) == ($past(enable) & ~$past(mask))));

    assert_master_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        master[1] |=> master[1]);
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]      pending,
    output logic [DATA_W-1:0] vector
);
    always_comb begin
        vector = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) vector = DATA_W'(i);
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int          NUM_LINES   = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] LEVEL_MASK  = 32'h0000_00FF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [IDX_W-1:0]     bus_idx,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_out
);
    localparam int VW = $clog2(NUM_LINES);

    bus_op_t              op;
    logic [NUM_LINES-1:0] sync_in, status, enable, ack_mask, pending;
    logic [1:0]           master;
    logic [DATA_W-1:0]    vector;

    assign op = make_op(bus_wr, bus_idx, bus_wdata);

    intc_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(irq_in), .dout(sync_in));

    intc_status #(.N(NUM_LINES), .LEVEL_MASK(LEVEL_MASK)) u_status (
        .clk(clk), .rst(rst), .sync_in(sync_in), .ack_mask(ack_mask), .status(status));

    intc_regs #(.N(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .op(op), .enable(enable), .master(master), .ack_mask(ack_mask));

    assign pending = status & enable;

    intc_prio #(.N(NUM_LINES)) u_prio (.pending(pending), .vector(vector));

    assign irq_out = (master == 2'b11) && (|pending);

    always_comb begin
        bus_rdata = '0;
        case (op.sel)
            SEL_STATUS: bus_rdata = DATA_W'(status);
            SEL_PEND:   bus_rdata = DATA_W'(pending);
            SEL_ENABLE: bus_rdata = DATA_W'(enable);
            SEL_VECTOR: bus_rdata = vector;
            SEL_MASTER: bus_rdata = DATA_W'(master);
            default:    bus_rdata = '0;
        endcase
    end

    // R11: a reported vector always names a pending line with nothing lower
    assert_vector_pending_R11: assert property (@(posedge clk) disable iff (rst)
        (vector != '1) |-> (pending[vector[VW-1:0]] &&
            ((pending & ((NUM_LINES'(1) << vector[VW-1:0]) - NUM_LINES'(1))) == '0)));

    // R10: the output needs a pending line
    assert_irq_needs_pending_R10: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (vector != '1));

    // R12: a write to a read-only index leaves enables unchanged
    assert_ro_write_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (op.sel == SEL_STATUS || op.sel == SEL_PEND || op.sel == SEL_VECTOR))
            |=> $stable(enable) && $stable(master));
endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;
    localparam int          N     = 32;
    localparam logic [31:0] LVL   = 32'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic [2:0]  bus_idx = 3'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit done = 0;

    intc_top #(.NUM_LINES(N), .SYNC_STAGES(2), .LEVEL_MASK(LVL)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_idx(bus_idx), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

    always #10 clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_in1, m_in2, m_last, m_stat, m_en;
    logic [1:0]  m_me;

    always @(posedge clk) begin
        logic [31:0] rise, setv, ack;
        if (rst) begin
            m_in1 = 0; m_in2 = 0; m_last = 0; m_stat = 0; m_en = 0; m_me = 0;
        end else begin
            rise = (m_in2 & LVL) | (m_in2 & ~m_last & ~LVL);
            ack  = (bus_wr && bus_idx == 3'd3) ? bus_wdata : 32'h0;
            setv = rise | (m_stat & ~ack);
            if (bus_wr) begin
                if (bus_idx == 3'd2) m_en = bus_wdata;
                if (bus_idx == 3'd4) m_en = m_en | bus_wdata;
                if (bus_idx == 3'd5) m_en = m_en & ~bus_wdata;
                if (bus_idx == 3'd7) m_me = {m_me[1] | bus_wdata[1], bus_wdata[0]};
            end
            m_stat = setv;
            m_last = m_in2;
            m_in2  = m_in1;
            m_in1  = irq_in;
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] idx);
        logic [31:0] p;
        logic [31:0] v;
        p = m_stat & m_en;
        v = 32'hFFFF_FFFF;
        for (int i = 31; i >= 0; i--) if (p[i]) v = i;
        case (idx)
            3'd0: return m_stat;
            3'd1: return p;
            3'd2: return m_en;
            3'd6: return v;
            3'd7: return {30'b0, m_me};
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] exp_r;
        logic        exp_i;
        exp_r = m_read(bus_idx);
        exp_i = (m_me == 2'b11) && ((m_stat & m_en) != 0);
        checks++;
        if (bus_rdata !== exp_r) begin
            errors++;
            $display("FAIL %s idx=%0d rdata actual=%h expected=%h", cur_req, bus_idx, bus_rdata, exp_r);
        end
        checks++;
        if (irq_out !== exp_i) begin
            errors++;
            $display("FAIL %s irq_out actual=%b expected=%b", cur_req, irq_out, exp_i);
        end
    endtask

    task automatic step(input logic [2:0] idx, input logic wr, input logic [31:0] d);
        @(negedge clk);
        if (!rst) compare();
        bus_idx = idx; bus_wr = wr; bus_wdata = d;
    endtask

    task automatic rd(input logic [2:0] idx);
        step(idx, 1'b0, 32'h0);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        step(idx, 1'b1, d);
    endtask

    task automatic sweep();
        for (int k = 0; k < 8; k++) rd(3'(k));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) rd(3'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1"; sweep();
        cur_req = "R8"; wr(3'd2, 32'hFFFF_0F0F); sweep();
        cur_req = "R6"; wr(3'd4, 32'h0000_F000); rd(3'd2); rd(3'd4);
        cur_req = "R7"; wr(3'd5, 32'h00FF_0000); rd(3'd2); rd(3'd5);
        cur_req = "R10"; wr(3'd7, 32'h1); rd(3'd7); wr(3'd7, 32'h2); rd(3'd7);
        wr(3'd7, 32'h0); rd(3'd7); wr(3'd7, 32'h3); rd(3'd7);
        cur_req = "R2"; irq_in[9] = 1'b1; rd(3'd0); rd(3'd0); rd(3'd0); rd(3'd0);
        cur_req = "R3"; idle(2); irq_in[9] = 1'b0; idle(4); rd(3'd1);
        cur_req = "R11"; rd(3'd6);
        irq_in[20] = 1'b1; idle(4);
        cur_req = "R9"; rd(3'd1); rd(3'd6);
        irq_in[12] = 1'b1; idle(4); rd(3'd6);
        cur_req = "R5"; wr(3'd3, 32'h0000_0200); rd(3'd0); rd(3'd6); rd(3'd1);
        cur_req = "R4"; irq_in[2] = 1'b1; idle(4); rd(3'd6);
        wr(3'd3, 32'h0000_0004); rd(3'd0); rd(3'd6);
        irq_in[2] = 1'b0; idle(3); wr(3'd3, 32'h0000_0004); rd(3'd0); rd(3'd6);
        cur_req = "R12"; wr(3'd0, 32'h0); wr(3'd1, 32'hFFFF_FFFF); wr(3'd6, 32'h0); sweep();
        cur_req = "R10"; wr(3'd7, 32'h0); rd(3'd7); rd(3'd1); wr(3'd7, 32'h1); rd(3'd7);
        cur_req = "R5"; irq_in[20] = 1'b0; irq_in[12] = 1'b0; idle(3);
        wr(3'd3, 32'hFFFF_FFFF); sweep();
        cur_req = "R11"; wr(3'd2, 32'hFFFF_FFFF); irq_in = 32'h8000_0400; idle(4); sweep();
        irq_in = '0; idle(2); wr(3'd3, 32'hFFFF_FFFF); sweep();
        rd(3'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule